// File: doc/BRIEF.md
# Attached Sync Marker Frame Synchronizer

The block watches a serial bit stream, one bit per cycle in which `bit_valid` is high, and looks for a 32-bit attached sync marker. A mask word chooses which marker bits take part in the comparison. Once a marker is found, the engine expects the next marker exactly one frame later. The frame is `frame_len` data bytes followed by the 32 marker bits. A programmable number of confirmed frames leads to lock. After lock, a programmable number of missed markers is tolerated while coasting in flywheel before the engine returns to search.

While frame sync is enabled, data leaves the block only as whole frames. Each frame is the `frame_len` bytes that follow a marker, packed MSB first. The marker bits are never forwarded. An optional status byte follows each frame and reports lock versus flywheel and the current flywheel miss count. With frame sync disabled, the block is a plain serial-to-byte packer with no alignment.

Top module: `asm_frame_sync`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` and `out_last` are 0 and `sync_state` reads SEARCH (encoding 0=SEARCH, 1=CHECK, 2=LOCK, 3=FLYWHEEL).
- R2: With `sync_en` low, every 8 valid bits counted from reset leave as one byte, first bit in bit 7. The byte appears with `out_valid` in the cycle after the edge that takes its eighth bit. `out_last` stays 0, `sync_state` stays SEARCH, and markers in the stream have no effect.
- R3: A marker bit takes part in the comparison only where its `marker_mask` bit is 1. `marker[31]` is compared with the earliest received bit of the 32-bit window. An all-zero mask matches at every bit position.
- R4: In SEARCH, every bit position is tested. A match moves the engine to CHECK, or straight to LOCK when `check_cnt` is 0. The next expected marker ends 8*L+32 bits after the matched one, where L is the frame length in bytes.
- R5: In CHECK, only the expected position is tested. After `check_cnt` further matches the engine enters LOCK. One miss returns it to SEARCH.
- R6: No byte is output while the engine is in SEARCH or CHECK with `sync_en` high.
- R7: In LOCK and FLYWHEEL, each frame is output as L bytes, MSB first, starting at the bit after the marker. `out_last` marks the final byte of the frame, which is the status byte when status is enabled.
- R8: A `frame_len` of 0 means a frame of 2^LEN_W bytes.
- R9: A miss at the expected position in LOCK enters FLYWHEEL with a miss count of 1, or SEARCH when `fly_cnt` is 0. In FLYWHEEL, a match returns to LOCK and clears the count. A miss when the count equals `fly_cnt` returns to SEARCH; otherwise the count increments.
- R10: With `stat_en` high, one status byte follows the data of each forwarded frame, one cycle after the last data byte. Bit 0 is 1 in LOCK and 0 in FLYWHEEL, bits 7:4 hold the flywheel miss count (0 in LOCK), and bits 3:1 are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Qualifies `bit_in` this cycle |
| bit_in | input | 1 | Serial data bit |
| sync_en | input | 1 | 1 = frame sync mode, 0 = raw packing |
| stat_en | input | 1 | Append a status byte after each frame |
| marker | input | MW | Sync marker pattern |
| marker_mask | input | MW | 1 = compare this marker bit |
| frame_len | input | LEN_W | Data bytes per frame, 0 = 2^LEN_W |
| check_cnt | input | 4 | Extra matches needed to lock |
| fly_cnt | input | 4 | Misses tolerated in flywheel |
| out_valid | output | 1 | Output byte strobe |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of a frame |
| sync_state | output | 2 | Engine state |

## Verification
The marker decision at the expected position falls in the same cycle as the restart of the frame bit counter. That cycle can change the state and the miss count that the next frame's bytes and status byte depend on. The bench provokes this by corrupting a marker between two locked frames, then restoring it, then corrupting several in a row. It judges the result from the status byte of each following frame (0x01, 0x10, 0x20) and from the absence of any output once the flywheel limit is passed. A second case places a marker exactly 2^LEN_W bytes after the first one. Lock must survive there, which shows that the zero length code and the expected position agree.

// File: rtl/asm_sync_pkg.sv
package asm_sync_pkg;
  localparam int CNT_W = 4;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_CHECK  = 2'd1,
    ST_LOCK   = 2'd2,
    ST_FLY    = 2'd3
  } sync_state_e;
endpackage

// File: rtl/asm_marker_window.sv
module asm_marker_window #(
  parameter int MW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_valid,
  input  logic          bit_in,
  input  logic [MW-1:0] pattern,
  input  logic [MW-1:0] mask,
  output logic          hit
);
  logic [MW-1:0] win_q;
  logic [MW-1:0] win_d;

  // newest bit enters at bit 0, so bit MW-1 is the oldest in the window
  always_comb begin
    win_d = {win_q[MW-2:0], bit_in};
    hit   = bit_valid && (((win_d ^ pattern) & mask) == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_q <= '0;
    else if (bit_valid) win_q <= win_d;
  end
endmodule

// File: rtl/asm_sync_fsm.sv
module asm_sync_fsm
  import asm_sync_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MW    = 32,
  localparam int POS_W = LEN_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              sync_en,
  input  logic              hit,
  input  logic [LEN_W-1:0]  frame_len,
  input  logic [CNT_W-1:0]  check_cnt,
  input  logic [CNT_W-1:0]  fly_cnt,
  output sync_state_e       state,
  output logic [POS_W-1:0]  bit_pos,
  output logic [POS_W-1:0]  frame_bits,
  output logic [CNT_W-1:0]  miss_cnt
);
  sync_state_e      state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d, last_pos;
  logic [CNT_W-1:0] hits_q, hits_d, miss_q, miss_d;
  logic             at_exp;

  always_comb begin
    frame_bits = {(frame_len == '0), frame_len, 3'b000};
    last_pos   = frame_bits + POS_W'(MW - 1);
    at_exp     = (pos_q == last_pos);
  end

  always_comb begin
    state_d = state_q;
    pos_d   = pos_q;
    hits_d  = hits_q;
    miss_d  = miss_q;
    if (!sync_en) begin
      state_d = ST_SEARCH;
      pos_d   = '0;
      hits_d  = '0;
      miss_d  = '0;
    end else if (bit_valid) begin
      if (state_q == ST_SEARCH) begin
        if (hit) begin
          pos_d   = '0;
          hits_d  = '0;
          miss_d  = '0;
          state_d = (check_cnt == '0) ? ST_LOCK : ST_CHECK;
        end
      end else begin
        pos_d = at_exp ? '0 : pos_q + POS_W'(1);
        if (at_exp) begin
          case (state_q)
            ST_CHECK: begin
              if (!hit)                                   state_d = ST_SEARCH;
              else if (hits_q + CNT_W'(1) == check_cnt)   state_d = ST_LOCK;
              else                                        hits_d  = hits_q + CNT_W'(1);
            end
            ST_LOCK: begin
              if (!hit) begin
                if (fly_cnt == '0) state_d = ST_SEARCH;
                else begin
                  state_d = ST_FLY;
                  miss_d  = CNT_W'(1);
                end
              end
            end
            ST_FLY: begin
              if (hit) begin
                state_d = ST_LOCK;
                miss_d  = '0;
              end else if (miss_q == fly_cnt) begin
                state_d = ST_SEARCH;
                miss_d  = '0;
              end else begin
                miss_d  = miss_q + CNT_W'(1);
              end
            end
            default: state_d = ST_SEARCH;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      pos_q   <= '0;
      hits_q  <= '0;
      miss_q  <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      hits_q  <= hits_d;
      miss_q  <= miss_d;
    end
  end

  assign state    = state_q;
  assign bit_pos  = pos_q;
  assign miss_cnt = miss_q;
endmodule

// File: rtl/asm_byte_packer.sv
module asm_byte_packer
  import asm_sync_pkg::*;
#(
  parameter int LEN_W = 16,
  localparam int POS_W = LEN_W + 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             sync_en,
  input  logic             stat_en,
  input  sync_state_e      state,
  input  logic [POS_W-1:0] bit_pos,
  input  logic [POS_W-1:0] frame_bits,
  input  logic [CNT_W-1:0] miss_cnt,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last
);
  logic [6:0] acc_q;
  logic [2:0] raw_q;
  logic       fwd, data_bit, byte_done, stat_pt, tail_bit;
  logic       valid_d, last_d;
  logic [7:0] data_d, status;

  always_comb begin
    fwd       = (state == ST_LOCK) || (state == ST_FLY);
    data_bit  = bit_pos < frame_bits;
    tail_bit  = bit_pos == frame_bits - POS_W'(1);
    byte_done = sync_en ? (fwd && data_bit && (bit_pos[2:0] == 3'd7))
                        : (raw_q == 3'd7);
    stat_pt   = sync_en && stat_en && fwd && (bit_pos == frame_bits);
    status    = {miss_cnt, 3'b000, (state == ST_LOCK)};
    valid_d   = bit_valid && (byte_done || stat_pt);
    data_d    = stat_pt ? status : {acc_q, bit_in};
    last_d    = bit_valid && sync_en &&
                (stat_en ? stat_pt : (byte_done && tail_bit));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      raw_q <= '0;
    end else begin
      if (bit_valid) acc_q <= {acc_q[5:0], bit_in};
      if (sync_en)        raw_q <= '0;
      else if (bit_valid) raw_q <= raw_q + 3'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      out_last  <= last_d;
      if (valid_d) out_data <= data_d;
    end
  end
endmodule

// File: rtl/asm_frame_sync.sv
module asm_frame_sync
  import asm_sync_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int MW    = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_valid,
  input  logic             bit_in,
  input  logic             sync_en,
  input  logic             stat_en,
  input  logic [MW-1:0]    marker,
  input  logic [MW-1:0]    marker_mask,
  input  logic [LEN_W-1:0] frame_len,
  input  logic [3:0]       check_cnt,
  input  logic [3:0]       fly_cnt,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [1:0]       sync_state
);
  localparam int POS_W = LEN_W + 4;

  logic             hit;
  sync_state_e      state;
  logic [POS_W-1:0] bit_pos, frame_bits;
  logic [CNT_W-1:0] miss_cnt;

  asm_marker_window #(.MW(MW)) i_window (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .pattern(marker), .mask(marker_mask), .hit(hit)
  );

  asm_sync_fsm #(.LEN_W(LEN_W), .MW(MW)) i_fsm (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .sync_en(sync_en),
    .hit(hit), .frame_len(frame_len), .check_cnt(check_cnt),
    .fly_cnt(fly_cnt), .state(state), .bit_pos(bit_pos),
    .frame_bits(frame_bits), .miss_cnt(miss_cnt)
  );

  asm_byte_packer #(.LEN_W(LEN_W)) i_packer (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_en(sync_en), .stat_en(stat_en), .state(state),
    .bit_pos(bit_pos), .frame_bits(frame_bits), .miss_cnt(miss_cnt),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  assign sync_state = state;
endmodule

// File: rtl/asm_frame_sync_chk.sv
module asm_frame_sync_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_valid,
  input logic       sync_en,
  input logic       out_valid,
  input logic       out_last,
  input logic [1:0] sync_state
);
  AST_OUT_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(bit_valid)); // R2

  AST_RAW_HOLDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_en |=> (sync_state == 2'd0)); // R2

  AST_SEARCH_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sync_state) == 2'd0 && sync_state != 2'd0) |->
      (sync_state == 2'd1 || sync_state == 2'd2)); // R4

  AST_CHECK_NOT_FLY: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd1) |=> (sync_state != 2'd3)); // R5

  AST_QUIET_IN_ACQUIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(sync_en)) |->
      ($past(sync_state) == 2'd2 || $past(sync_state) == 2'd3)); // R6

  AST_LAST_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid); // R7

  AST_FLY_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_state == 2'd3 && $past(sync_state) != 2'd3) |->
      ($past(sync_state) == 2'd2)); // R9
endmodule

bind asm_frame_sync asm_frame_sync_chk i_chk (
  .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .sync_en(sync_en),
  .out_valid(out_valid), .out_last(out_last), .sync_state(sync_state)
);

// File: tb/test_asm_frame_sync.sv
`timescale 1ns/1ps
module test_asm_frame_sync;
  localparam int LW = 8;
  localparam logic [31:0] MK  = 32'h1ACF_FC1D;
  localparam logic [31:0] BAD = 32'h1ACF_FC1C;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, bit_valid, bit_in, sync_en, stat_en;
  logic [31:0]   marker, marker_mask;
  logic [LW-1:0] frame_len;
  logic [3:0]    check_cnt, fly_cnt;
  logic          out_valid, out_last;
  logic [7:0]    out_data;
  logic [1:0]    sync_state;

  int checks = 0;
  int fails  = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  asm_frame_sync #(.LEN_W(LW), .MW(32)) i_asm_frame_sync (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .sync_en(sync_en), .stat_en(stat_en), .marker(marker),
    .marker_mask(marker_mask), .frame_len(frame_len),
    .check_cnt(check_cnt), .fly_cnt(fly_cnt), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last), .sync_state(sync_state)
  );

  task automatic check(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_in    = b;
    bit_valid = 1'b1;
    @(posedge clk);
    #1;
    bit_valid = 1'b0;
    if (out_valid) got_q.push_back({out_last, out_data});
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic expect_byte(input logic last, input logic [7:0] v);
    exp_q.push_back({last, v});
  endtask

  task automatic compare_q(input string req);
    check({req, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < got_q.size() && i < exp_q.size(); i++)
      check(req, int'(got_q[i]), int'(exp_q[i]));
  endtask

  task automatic do_reset(input logic s, input logic st, input int len,
                          input int chk, input int fly, input logic [31:0] msk);
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
    sync_en = s; stat_en = st; marker = MK; marker_mask = msk;
    frame_len = LW'(len); check_cnt = 4'(chk); fly_cnt = 4'(fly);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic t_reset();
    do_reset(1'b1, 1'b0, 4, 0, 0, 32'hFFFF_FFFF);
    @(negedge clk);
    check("R1 out_valid", out_valid, 0);
    check("R1 out_last", out_last, 0);
    check("R1 state", sync_state, 0);
  endtask

  task automatic t_raw();
    do_reset(1'b0, 1'b1, 4, 0, 0, 32'hFFFF_FFFF);
    send_word(MK);
    send_byte(8'h3C);
    expect_byte(0, 8'h1A); expect_byte(0, 8'hCF);
    expect_byte(0, 8'hFC); expect_byte(0, 8'h1D);
    expect_byte(0, 8'h3C);
    compare_q("R2 raw bytes");
    check("R2 state", sync_state, 0);
  endtask

  task automatic t_acquire();
    do_reset(1'b1, 1'b0, 4, 2, 1, 32'hFFFF_FFFF);
    send_bit(1); send_bit(0); send_bit(1); send_bit(1); send_bit(0);
    send_word(MK);
    check("R4 state after first marker", sync_state, 1);
    send_byte(8'h11); send_byte(8'h22); send_byte(8'h33); send_byte(8'h44);
    send_word(MK);
    check("R5 still checking", sync_state, 1);
    send_byte(8'h55); send_byte(8'h66); send_byte(8'h77); send_byte(8'h88);
    send_word(MK);
    check("R5 locked", sync_state, 2);
    check("R6 quiet during check", got_q.size(), 0);
    send_byte(8'hA1); send_byte(8'hA2); send_byte(8'hA3); send_byte(8'hA4);
    send_word(MK);
    expect_byte(0, 8'hA1); expect_byte(0, 8'hA2);
    expect_byte(0, 8'hA3); expect_byte(1, 8'hA4);
    compare_q("R7 locked frame");
  endtask

  task automatic t_check_miss();
    do_reset(1'b1, 1'b0, 2, 3, 1, 32'hFFFF_FFFF);
    send_word(MK);
    send_byte(8'h12); send_byte(8'h34);
    send_word(BAD);
    check("R5 miss in check", sync_state, 0);
    check("R6 nothing out", got_q.size(), 0);
  endtask

  task automatic t_mask();
    do_reset(1'b1, 1'b0, 2, 0, 0, 32'hFFFF_0000);
    send_word(MK ^ 32'h0000_B6E1);
    check("R3 masked match locks", sync_state, 2);
    send_byte(8'h5A); send_byte(8'hC3);
    send_word(MK ^ 32'h0000_0F0F);
    expect_byte(0, 8'h5A); expect_byte(1, 8'hC3);
    compare_q("R3 R7 masked frame");
    check("R3 masked expected marker", sync_state, 2);
  endtask

  task automatic t_flywheel();
    do_reset(1'b1, 1'b1, 2, 0, 2, 32'hFFFF_FFFF);
    send_word(MK);
    send_byte(8'h01); send_byte(8'h02); send_word(BAD);
    check("R9 lock miss to flywheel", sync_state, 3);
    send_byte(8'h03); send_byte(8'h04); send_word(MK);
    check("R9 flywheel match to lock", sync_state, 2);
    send_byte(8'h05); send_byte(8'h06); send_word(BAD);
    send_byte(8'h07); send_byte(8'h08); send_word(BAD);
    check("R9 second miss tolerated", sync_state, 3);
    send_byte(8'h09); send_byte(8'h0A); send_word(BAD);
    check("R9 limit reached", sync_state, 0);
    send_byte(8'hEE); send_byte(8'hEE);
    expect_byte(0, 8'h01); expect_byte(0, 8'h02); expect_byte(1, 8'h01);
    expect_byte(0, 8'h03); expect_byte(0, 8'h04); expect_byte(1, 8'h10);
    expect_byte(0, 8'h05); expect_byte(0, 8'h06); expect_byte(1, 8'h01);
    expect_byte(0, 8'h07); expect_byte(0, 8'h08); expect_byte(1, 8'h10);
    expect_byte(0, 8'h09); expect_byte(0, 8'h0A); expect_byte(1, 8'h20);
    compare_q("R10 status stream");
  endtask

  task automatic t_fly_zero();
    do_reset(1'b1, 1'b0, 1, 0, 0, 32'hFFFF_FFFF);
    send_word(MK);
    send_byte(8'hAA);
    send_word(BAD);
    check("R9 zero flywheel to search", sync_state, 0);
    expect_byte(1, 8'hAA);
    compare_q("R7 single byte frame");
  endtask

  task automatic t_len_zero();
    do_reset(1'b1, 1'b0, 0, 0, 0, 32'hFFFF_FFFF);
    send_word(MK);
    for (int i = 0; i < (1 << LW); i++) begin
      send_byte(8'(i * 7 + 3));
      expect_byte(i == (1 << LW) - 1, 8'(i * 7 + 3));
    end
    send_word(MK);
    check("R8 lock held at full length", sync_state, 2);
    compare_q("R8 full length frame");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_raw();
    t_acquire();
    t_check_miss();
    t_mask();
    t_flywheel();
    t_fly_zero();
    t_len_zero();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule